// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block lets clocked logic read and write single bytes in an external 128K x 8 asynchronous static RAM. A requester offers one operation at a time on a valid/ready port; the controller turns it into a timed sequence of address, chip-select, write-strobe and output-strobe levels on the memory pins. The bidirectional data pins are handled as three separate signals: a drive value, a drive enable and a sampled input, so a pad cell outside the block can join them.

Every pin phase is stretched to a whole number of clock cycles. The count is derived from the memory's nanosecond limits and the clock period, so the same RTL can serve other clock rates by changing parameters. A write is always ended by write enable rising while both chip selects stay asserted. The address and data are held for one more phase after that edge. After a read, a turnaround phase keeps the controller off the data pins until the memory has certainly released them. Read data comes back on a response port, marked by a single-cycle strobe.

Top module: `async_sram_ctrl`

## Requirements
- R1: Out of reset and whenever no operation is in progress, the memory is deselected (first chip select high, second chip select low), write strobe and output strobe are high, data drive enable is low, `req_ready` is high and `rsp_valid` is low.
- R2: The memory counts as selected only when the first chip select is low and the second is high. The controller changes the two together: it selects in every access phase and deselects in every other cycle.
- R3: An accepted write gives, from the cycle after acceptance, a setup phase (selected, write strobe high, address and data driven), then a pulse phase with the write strobe low, then a hold phase with the write strobe high again. Chip selects, address and data stay unchanged through the hold phase. The output strobe stays high throughout.
- R4: An accepted read gives, from the cycle after acceptance, an access phase with the memory selected, write strobe high, output strobe low and data drive off. The data pins are sampled at the clock edge that ends the access phase. The sampled byte appears on `rsp_rdata`, with `rsp_valid` high for exactly the one following cycle.
- R5: Each read is followed by a turnaround phase in which the memory is deselected, the output strobe is high and the controller does not drive the data pins. Only after this phase does `req_ready` return high.
- R6: A request is taken only in a cycle where `req_valid` and `req_ready` are both high. `req_ready` is low from the cycle after acceptance until the operation is finished. Request fields offered while `req_ready` is low change no pin, and the memory is not written by them.
- R7: The controller never drives the data pins while the output strobe is low, and it starts driving no sooner than the turnaround allows after the output strobe rises.
- R8: Each phase lasts ceil(ns / clock period) cycles, and at least one. The write pulse also covers the strobe width, the data setup, the address-to-end time and the write cycle time. The read access covers the address access, output-strobe access and read cycle times. With an 8 ns clock and the default limits, this gives setup 1, pulse 5, hold 1, access 6 and turnaround 3 cycles.
- R9: A read returns the byte most recently written to the same address. This holds across both ends of the address range (0x00000 and 0x1FFFF).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | One-cycle strobe: read data valid |
| rsp_rdata | output | 8 | Byte read |
| mem_addr | output | 17 | Memory address pins |
| mem_ce1_n | output | 1 | First chip select, active low |
| mem_ce2 | output | 1 | Second chip select, active high |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output strobe, active low |
| mem_dq_out | output | 8 | Value driven onto the data pins |
| mem_dq_oe | output | 1 | Data pin drive enable |
| mem_dq_in | input | 8 | Value sampled from the data pins |

## Verification
A request accepted at one rising edge shows its first pin phase in the very next cycle. A write then spans 7 cycles of pin activity and a read 9. The read byte is due on the response port in the first turnaround cycle, 7 cycles after acceptance. The bench pushes one expected pin record per cycle into a queue when it offers a request, and at each falling edge it compares the pins with the head of that queue. An empty queue means the idle pattern with ready high. The memory model returns valid data only once the select, address and output-strobe times have been met. It keeps driving for three cycles after the output strobe rises, so a phase that is too short shows up as wrong data or as bus contention in the same cycle.

// File: rtl/sram_ctl_pkg.sv
// Package: shared phase type and the ns-to-cycle helpers used to size
// every phase of the asynchronous SRAM controller.
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_WSETUP = 3'd1,
        PH_WPULSE = 3'd2,
        PH_WHOLD  = 3'd3,
        PH_RACC   = 3'd4,
        PH_RTURN  = 3'd5
    } phase_e;

    // Whole cycles covering ns at the given period, never fewer than one.
    function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned per_ns);
        int unsigned c;
        c = (ns + per_ns - 1) / per_ns;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int unsigned umax(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Difference clipped at zero.
    function automatic int unsigned usub0(int unsigned a, int unsigned b);
        return (a > b) ? (a - b) : 0;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
// Down-counter that times one pin phase.
// Assumes: load has priority; last is high in the final cycle of a phase
// loaded with (length - 1).
module sram_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);

    logic [CNT_W-1:0] cnt_q;

    // Reload at a phase start, else count down to zero and rest there.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last = (cnt_q == '0);

endmodule

// File: rtl/sram_ctl_seq.sv
// Phase sequencer: walks write (setup, pulse, hold) or read (access,
// turnaround) phases and reloads the phase timer at each boundary.
// Assumes: phase lengths are at least one cycle; a request is taken only in idle.
module sram_ctl_seq
    import sram_ctl_pkg::*;
#(
    parameter int CNT_W   = 4,
    parameter int SETUP_C = 1,
    parameter int PULSE_C = 5,
    parameter int HOLD_C  = 1,
    parameter int ACC_C   = 6,
    parameter int TURN_C  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             phase_last,
    output phase_e           phase_q,
    output phase_e           phase_d,
    output logic             accept,
    output logic             req_ready,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val
);

    localparam logic [CNT_W-1:0] SETUP_L = CNT_W'(SETUP_C - 1);
    localparam logic [CNT_W-1:0] PULSE_L = CNT_W'(PULSE_C - 1);
    localparam logic [CNT_W-1:0] HOLD_L  = CNT_W'(HOLD_C - 1);
    localparam logic [CNT_W-1:0] ACC_L   = CNT_W'(ACC_C - 1);
    localparam logic [CNT_W-1:0] TURN_L  = CNT_W'(TURN_C - 1);

    assign req_ready = (phase_q == PH_IDLE);
    assign accept    = req_ready && req_valid;

    // Next phase and timer reload for the coming phase.
    always_comb begin
        phase_d  = phase_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (phase_q)
            PH_IDLE: if (req_valid) begin
                tmr_load = 1'b1;
                if (req_write) begin
                    phase_d = PH_WSETUP;
                    tmr_val = SETUP_L;
                end else begin
                    phase_d = PH_RACC;
                    tmr_val = ACC_L;
                end
            end
            PH_WSETUP: if (phase_last) begin
                phase_d  = PH_WPULSE;
                tmr_load = 1'b1;
                tmr_val  = PULSE_L;
            end
            PH_WPULSE: if (phase_last) begin
                phase_d  = PH_WHOLD;
                tmr_load = 1'b1;
                tmr_val  = HOLD_L;
            end
            PH_WHOLD: if (phase_last) phase_d = PH_IDLE;
            PH_RACC: if (phase_last) begin
                phase_d  = PH_RTURN;
                tmr_load = 1'b1;
                tmr_val  = TURN_L;
            end
            PH_RTURN: if (phase_last) phase_d = PH_IDLE;
            default: phase_d = PH_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    // R6: after a request is taken the port must be closed next cycle.
    p_busy_after_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready);

    // R3: a write pulse is always followed by the hold phase, never idle.
    p_pulse_to_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_WPULSE) |=> (phase_q == PH_WPULSE || phase_q == PH_WHOLD));

    // R5: a read access always passes through turnaround before idle.
    p_acc_to_turn_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_RACC) |=> (phase_q == PH_RACC || phase_q == PH_RTURN));

endmodule

// File: rtl/sram_pin_ctrl.sv
// Pin stage: registers address and write data at acceptance, registers the
// strobes from the next phase so every pin leaves a flop, and captures the
// read byte on the edge that ends the access phase.
// Assumes: phase_d is the sequencer's next phase; phase_q/phase_last its current.
module sram_pin_ctrl
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W  = 17,
    parameter int DATA_W  = 8,
    parameter int CNT_W   = 4,
    parameter int PULSE_C = 5,
    parameter int TURN_C  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  phase_e            phase_q,
    input  phase_e            phase_d,
    input  logic              phase_last,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce1_n,
    output logic              mem_ce2,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);

    localparam logic [CNT_W-1:0] PULSE_K = CNT_W'(PULSE_C);
    localparam logic [CNT_W-1:0] TURN_K  = CNT_W'(TURN_C);

    logic sel_d, we_d, oe_d, drv_d;

    // Strobe levels wanted in the coming phase.
    always_comb begin
        sel_d = (phase_d == PH_WSETUP) || (phase_d == PH_WPULSE) ||
                (phase_d == PH_WHOLD)  || (phase_d == PH_RACC);
        we_d  = (phase_d == PH_WPULSE);
        oe_d  = (phase_d == PH_RACC);
        drv_d = (phase_d == PH_WSETUP) || (phase_d == PH_WPULSE) ||
                (phase_d == PH_WHOLD);
    end

    // Strobe flops; reset leaves the memory deselected and the bus released.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_ce1_n <= 1'b1;
            mem_ce2   <= 1'b0;
            mem_we_n  <= 1'b1;
            mem_oe_n  <= 1'b1;
            mem_dq_oe <= 1'b0;
        end else begin
            mem_ce1_n <= !sel_d;
            mem_ce2   <= sel_d;
            mem_we_n  <= !we_d;
            mem_oe_n  <= !oe_d;
            mem_dq_oe <= drv_d;
        end
    end

    // Address and write data held from acceptance to the next acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr   <= '0;
            mem_dq_out <= '0;
        end else if (accept) begin
            mem_addr   <= req_addr;
            mem_dq_out <= req_wdata;
        end
    end

    // Read capture at the last access cycle and one-cycle response strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= (phase_q == PH_RACC) && phase_last;
            if ((phase_q == PH_RACC) && phase_last) rsp_rdata <= mem_dq_in;
        end
    end

    // Checker support: length of the current write-strobe low run.
    logic [CNT_W-1:0] we_lo_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n)                                    we_lo_cnt <= '0;
        else if (!mem_we_n && we_lo_cnt != PULSE_K)    we_lo_cnt <= we_lo_cnt + 1'b1;
        else if (mem_we_n)                             we_lo_cnt <= '0;
    end

    // Checker support: cycles since the output strobe was last low (saturating).
    logic [CNT_W-1:0] oe_gap_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n)                    oe_gap_cnt <= TURN_K;
        else if (!mem_oe_n)            oe_gap_cnt <= '0;
        else if (oe_gap_cnt != TURN_K) oe_gap_cnt <= oe_gap_cnt + 1'b1;
    end

    // R2: the two chip selects always agree on selected / deselected.
    p_ce_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_ce1_n == !mem_ce2));

    // R3: the write strobe is low only while the memory is selected and data driven.
    p_we_inside_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce1_n && mem_ce2 && mem_dq_oe && mem_oe_n));

    // R3: a write ends on the strobe edge with selects, address and data held.
    p_we_end_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (!mem_ce1_n && mem_ce2 && mem_dq_oe &&
                             $stable(mem_addr) && $stable(mem_dq_out)));

    // R8: the write strobe low run reaches the full pulse length.
    p_we_width_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_lo_cnt == PULSE_K));

    // R7: no drive while the memory may be driving.
    p_no_fight_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_dq_oe);

    // R7: drive starts only after the full turnaround following an output strobe.
    p_turn_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> (oe_gap_cnt == TURN_K));

    // R4: the response strobe lasts one cycle.
    p_rsp_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/async_sram_ctrl.sv
// Top: sizes all phases from nanosecond limits and the clock period, then
// ties together the phase timer, the sequencer and the pin stage.
// Assumes: one clock domain; the data pins are joined by a pad outside.
module async_sram_ctrl
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W  = 17,
    parameter int DATA_W  = 8,
    parameter int CLK_NS  = 8,
    parameter int T_RC    = 45,
    parameter int T_AA    = 45,
    parameter int T_DOE   = 22,
    parameter int T_HZOE  = 18,
    parameter int T_WC    = 45,
    parameter int T_PWE   = 35,
    parameter int T_AW    = 35,
    parameter int T_SA    = 0,
    parameter int T_HA    = 0,
    parameter int T_SD    = 25,
    parameter int T_HD    = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce1_n,
    output logic              mem_ce2,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);

    localparam int SETUP_C = ns_to_cyc(T_SA, CLK_NS);
    localparam int HOLD_C  = ns_to_cyc(umax(T_HA, T_HD), CLK_NS);
    localparam int PULSE_C = umax(umax(ns_to_cyc(T_PWE, CLK_NS), ns_to_cyc(T_SD, CLK_NS)),
                                  umax(usub0(ns_to_cyc(T_AW, CLK_NS), SETUP_C),
                                       usub0(ns_to_cyc(T_WC, CLK_NS), SETUP_C + HOLD_C)));
    localparam int ACC_C   = umax(umax(ns_to_cyc(T_AA, CLK_NS), ns_to_cyc(T_DOE, CLK_NS)),
                                  ns_to_cyc(T_RC, CLK_NS));
    localparam int TURN_C  = ns_to_cyc(T_HZOE, CLK_NS);
    localparam int MAX_C   = umax(umax(umax(SETUP_C, HOLD_C), umax(PULSE_C, ACC_C)), TURN_C);
    localparam int CNT_W   = $clog2(MAX_C + 1);

    phase_e           phase_q, phase_d;
    logic             phase_last, accept, tmr_load;
    logic [CNT_W-1:0] tmr_val;

    sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (phase_last)
    );

    sram_ctl_seq #(
        .CNT_W(CNT_W), .SETUP_C(SETUP_C), .PULSE_C(PULSE_C),
        .HOLD_C(HOLD_C), .ACC_C(ACC_C), .TURN_C(TURN_C)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .phase_last (phase_last),
        .phase_q    (phase_q),
        .phase_d    (phase_d),
        .accept     (accept),
        .req_ready  (req_ready),
        .tmr_load   (tmr_load),
        .tmr_val    (tmr_val)
    );

    sram_pin_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
        .PULSE_C(PULSE_C), .TURN_C(TURN_C)
    ) u_pins (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase_q    (phase_q),
        .phase_d    (phase_d),
        .phase_last (phase_last),
        .accept     (accept),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .mem_addr   (mem_addr),
        .mem_ce1_n  (mem_ce1_n),
        .mem_ce2    (mem_ce2),
        .mem_we_n   (mem_we_n),
        .mem_oe_n   (mem_oe_n),
        .mem_dq_out (mem_dq_out),
        .mem_dq_oe  (mem_dq_oe),
        .mem_dq_in  (mem_dq_in),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata)
    );

    // R1: with the sequencer idle, the pins show the quiet pattern.
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_IDLE) |-> (mem_ce1_n && !mem_ce2 && mem_we_n &&
                                  mem_oe_n && !mem_dq_oe && !rsp_valid));

    // R5: in turnaround the memory is deselected and the bus released.
    p_turn_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_RTURN) |-> (mem_ce1_n && mem_oe_n && !mem_dq_oe && !req_ready));

endmodule

// File: tb/async_sram_ctrl_bench.sv
`timescale 1ns/1ps
// Bench: per-cycle expected pin records queued at request time, a
// behavioural SRAM with timing checks, and a byte scoreboard.
module async_sram_ctrl_bench;

    localparam int CLK_NS = 8;
    localparam int SETUP_C = 1, PULSE_C = 5, HOLD_C = 1, ACC_C = 6, TURN_C = 3; // R8
    localparam int TRAIL_C = 3;   // cycles the memory may still drive (18 ns)

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [16:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rsp_valid;
    logic [7:0]  rsp_rdata;
    logic [16:0] mem_addr;
    logic        mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in = '0;

    always #(CLK_NS/2) clk = ~clk;

    async_sram_ctrl u_async_sram_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    typedef struct {
        bit        sel, we_n, oe_n, drv, rv;
        bit [16:0] addr;
        bit [7:0]  data;
    } rec_t;

    typedef struct {
        bit        wr;
        bit [16:0] a;
        bit [7:0]  d;
        int        gap;
    } op_t;

    rec_t exp_q[$];
    op_t  ops[$];
    bit [7:0] model_mem [int];
    bit [7:0] sb_mem [int];

    int vectors = 0, miscompares = 0, cyc = 0, gap_left = 0;
    bit done = 1'b0;

    // Model state.
    bit [16:0] m_addr_prev = '0;
    int m_addr_cnt = 0, m_oe_cnt = 0, m_sel_cnt = 0, m_trail = 0;
    int m_we_lo = 0, m_d_cnt = 0;
    bit [7:0] m_d_prev = '0;
    bit m_prev_we = 1'b1;

    function automatic bit [7:0] dflt(bit [16:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    function automatic bit [7:0] sb_rd(bit [16:0] a);
        return sb_mem.exists(int'(a)) ? sb_mem[int'(a)] : dflt(a);
    endfunction

    function automatic bit [7:0] mm_rd(bit [16:0] a);
        return model_mem.exists(int'(a)) ? model_mem[int'(a)] : dflt(a);
    endfunction

    task automatic chk(string req, string what, int act, int expv);
        vectors++;
        if (act != expv) begin
            miscompares++;
            $display("FAIL %s %s act=%0h exp=%0h (cycle %0d)", req, what, act, expv, cyc);
        end
    endtask

    function automatic rec_t mk(bit sel, bit we_n, bit oe_n, bit drv, bit [16:0] a, bit [7:0] d);
        rec_t r;
        r.sel = sel; r.we_n = we_n; r.oe_n = oe_n; r.drv = drv;
        r.rv = 1'b0; r.addr = a; r.data = d;
        return r;
    endfunction

    // Queue the per-cycle pin records of one operation (R3, R4, R5).
    task automatic push_op(op_t o);
        rec_t r;
        if (o.wr) begin
            for (int i = 0; i < SETUP_C; i++) exp_q.push_back(mk(1, 1, 1, 1, o.a, o.d));
            for (int i = 0; i < PULSE_C; i++) exp_q.push_back(mk(1, 0, 1, 1, o.a, o.d));
            for (int i = 0; i < HOLD_C; i++)  exp_q.push_back(mk(1, 1, 1, 1, o.a, o.d));
            sb_mem[int'(o.a)] = o.d;
        end else begin
            for (int i = 0; i < ACC_C; i++) exp_q.push_back(mk(1, 1, 0, 0, o.a, 8'h00));
            for (int i = 0; i < TURN_C; i++) begin
                r = mk(0, 1, 1, 0, o.a, sb_rd(o.a));
                r.rv = (i == 0);
                exp_q.push_back(r);
            end
        end
    endtask

    // Behavioural memory: timing checks, data return, drive tracking.
    task automatic model_step();
        bit sel, drv, dvalid;
        sel = !mem_ce1_n && mem_ce2;
        if (mem_addr == m_addr_prev) m_addr_cnt++; else m_addr_cnt = 1;
        m_addr_prev = mem_addr;
        if (sel) m_sel_cnt++; else m_sel_cnt = 0;
        if (sel && !mem_oe_n && mem_we_n) m_oe_cnt++; else m_oe_cnt = 0;
        drv = 1'b0;
        if (m_oe_cnt > 0) begin
            drv = 1'b1; m_trail = TRAIL_C;
        end else if (m_trail > 0) begin
            drv = 1'b1; m_trail--;
        end
        dvalid = (m_oe_cnt * CLK_NS >= 22) && (m_sel_cnt * CLK_NS >= 45) &&
                 (m_addr_cnt * CLK_NS >= 45);
        mem_dq_in = !drv ? 8'h00 : (dvalid ? mm_rd(mem_addr) : ~mm_rd(mem_addr));
        if (drv) chk("R7", "bus contention", int'(mem_dq_oe), 0);
        if (mem_dq_oe && mem_dq_out == m_d_prev) m_d_cnt++;
        else m_d_cnt = mem_dq_oe ? 1 : 0;
        m_d_prev = mem_dq_out;
        if (!mem_we_n && sel) m_we_lo++;
        if (mem_we_n && !m_prev_we) begin
            chk("R3", "select held past write end", int'(sel), 1);
            chk("R3", "data held past write end", int'(mem_dq_oe), 1);
            chk("R8", "write pulse >= 35ns", int'(m_we_lo * CLK_NS >= 35), 1);
            chk("R8", "addr setup to end >= 35ns", int'((m_addr_cnt - 1) * CLK_NS >= 35), 1);
            chk("R8", "data setup to end >= 25ns", int'((m_d_cnt - 1) * CLK_NS >= 25), 1);
            if (sel) model_mem[int'(mem_addr)] = mem_dq_out;
            m_we_lo = 0;
        end
        m_prev_we = mem_we_n;
    endtask

    // Compare pins with this cycle's record, then drive the next stimulus.
    always @(negedge clk) begin
        rec_t e;
        bit idle;
        cyc++;
        if (!rst_n) begin
            req_valid <= 1'b0;
        end else if (!done) begin
            model_step();
            idle = (exp_q.size() == 0);
            if (idle) begin
                chk("R1", "ce1_n idle", int'(mem_ce1_n), 1);
                chk("R2", "ce2 idle", int'(mem_ce2), 0);
                chk("R1", "we_n idle", int'(mem_we_n), 1);
                chk("R1", "oe_n idle", int'(mem_oe_n), 1);
                chk("R1", "dq_oe idle", int'(mem_dq_oe), 0);
                chk("R1", "rsp_valid idle", int'(rsp_valid), 0);
                chk("R6", "ready idle", int'(req_ready), 1);
            end else begin
                e = exp_q.pop_front();
                chk("R2", "ce1_n", int'(mem_ce1_n), int'(!e.sel));
                chk("R2", "ce2", int'(mem_ce2), int'(e.sel));
                chk("R3", "we_n", int'(mem_we_n), int'(e.we_n));
                chk("R4", "oe_n", int'(mem_oe_n), int'(e.oe_n));
                chk("R5", "dq_oe", int'(mem_dq_oe), int'(e.drv));
                chk("R6", "ready busy", int'(req_ready), 0);
                chk("R4", "rsp_valid", int'(rsp_valid), int'(e.rv));
                if (e.sel) chk("R6", "addr", int'(mem_addr), int'(e.addr));
                if (e.drv) chk("R3", "dq_out", int'(mem_dq_out), int'(e.data));
                if (e.rv)  chk("R9", "read data", int'(rsp_rdata), int'(e.data));
            end
            if (idle) begin
                if (ops.size() == 0) begin
                    req_valid <= 1'b0;
                    done = 1'b1;
                end else if (gap_left > 0) begin
                    gap_left--;
                    req_valid <= 1'b0;
                end else begin
                    req_valid <= 1'b1;
                    req_write <= ops[0].wr;
                    req_addr  <= ops[0].a;
                    req_wdata <= ops[0].d;
                    push_op(ops[0]);
                    void'(ops.pop_front());
                    gap_left = (ops.size() > 0) ? ops[0].gap : 0;
                end
            end else begin
                // R6: junk offered while busy must be ignored.
                req_valid <= (ops.size() > 0);
                req_write <= 1'b1;
                req_addr  <= 17'h0AAAA;
                req_wdata <= 8'hEE;
            end
        end
    end

    task automatic add(bit wr, bit [16:0] a, bit [7:0] d, int gap);
        op_t o;
        o.wr = wr; o.a = a; o.d = d; o.gap = gap;
        ops.push_back(o);
    endtask

    initial begin
        add(1, 17'h00000, 8'h3C, 0);   // R9 low end
        add(1, 17'h1FFFF, 8'hA5, 2);   // R9 high end
        add(0, 17'h1FFFF, 8'h00, 0);   // write then read back to back, R7
        add(1, 17'h12345, 8'h00, 0);   // read then write, R5 turnaround
        add(0, 17'h00000, 8'h00, 1);
        add(0, 17'h12345, 8'h00, 0);
        add(0, 17'h0F0F0, 8'h00, 0);   // never written
        add(1, 17'h0F0F0, 8'hFF, 3);
        add(0, 17'h0F0F0, 8'h00, 0);
        add(1, 17'h00000, 8'h81, 0);   // overwrite
        add(0, 17'h00000, 8'h00, 0);
        add(0, 17'h0AAAA, 8'h00, 0);   // R6: junk write never landed
        gap_left = ops[0].gap;

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state, checked while reset is held.
        chk("R1", "ce1_n reset", int'(mem_ce1_n), 1);
        chk("R1", "ce2 reset", int'(mem_ce2), 0);
        chk("R1", "we_n reset", int'(mem_we_n), 1);
        chk("R1", "oe_n reset", int'(mem_oe_n), 1);
        chk("R1", "dq_oe reset", int'(mem_dq_oe), 0);
        chk("R1", "ready reset", int'(req_ready), 1);
        chk("R1", "rsp_valid reset", int'(rsp_valid), 0);
        rst_n = 1'b1;

        wait (done || cyc >= 20000);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog act=%0d exp=done", cyc);
        end
        repeat (4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule